// File: doc/BRIEF.md
# Serial Audio Polarity Splitter

This block takes a stereo serial audio stream (bit clock, word select, serial data) and produces, for each bit, a straight copy and a polarity-inverted copy, so that a pair of converters can be driven in a balanced arrangement. Each channel occupies a slot of `SLOT_BITS` bit clocks. Word select is low for the left slot and high for the right slot. It changes one bit clock before the first sample bit of the next slot. The sample is `SAMPLE_BITS` wide, two's complement, most significant bit first. The block counts bit positions from each word-select change, so it knows exactly where the sample window and its least significant bit sit.

The inverted output has two modes. The flip mode inverts every sample bit except the least significant one, which passes through unchanged. The negate mode captures each whole sample, forms its exact two's-complement negation, and shifts the result out in the following slot. The most negative code saturates to the most positive code. In negate mode, a separate word-select output delayed by one slot travels with the inverted data. A two-tap delay line gives the straight stream delayed by one and by two slot lengths, so that channels can be realigned downstream.

All logic samples on the rising bit-clock edge, and every output changes on the falling edge. After reset, all outputs stay at zero until the block has counted a full word-select period.

Top module: `audio_polarity_split`

## Requirements
- R1: Position 0 is the bit sampled on a rising edge at which word select differs from its previously sampled value. The first sample after reset never counts as a change. Sample bits occupy positions 1 to 16, with position 1 carrying bit 15 (MSB) and position 16 carrying bit 0 (LSB).
- R2: All six outputs are 0 during reset and until the second word-select change after reset. The first slot emitted is the one that begins at that second change.
- R3: `sd_o` equals the input bit at positions 1 to 16 and is 0 at position 0 and at positions 17 to 31.
- R4: With `exact_i`=0, `sd_inv_o` is the complement of the input bit at positions 1 to 15, equals the input bit at position 16, and is 0 outside positions 1 to 16.
- R5: With `exact_i`=1, `sd_inv_o` at positions 1 to 16 of a slot carries the 16-bit two's-complement negation (~x+1) of the sample of the previous slot, MSB first. It is 0 elsewhere and throughout the first emitted slot.
- R6: In negate mode, the sample 16'h8000 is emitted as 16'h7FFF.
- R7: `ws_o` follows the sampled word select. `ws_inv_o` equals `ws_o` with `exact_i`=0, and equals `ws_o` delayed by 32 bit clocks with `exact_i`=1.
- R8: `sd_dly1_o` and `sd_dly2_o` equal `sd_o` delayed by 32 and by 64 bit clocks, and are 0 before those delays have filled since reset.
- R9: Inputs are sampled on the rising edge of `clk_i`, and outputs change only on the falling edge, half a cycle after the sample they carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ws_i | input | 1 | Word select: 0 for left slot, 1 for right slot |
| sd_i | input | 1 | Serial sample data, MSB first |
| exact_i | input | 1 | 0 selects flip mode, 1 selects exact negate mode |
| sd_o | output | 1 | Straight data, zeroed outside the sample window |
| sd_inv_o | output | 1 | Polarity-inverted data |
| ws_o | output | 1 | Word select matching `sd_o` |
| ws_inv_o | output | 1 | Word select matching `sd_inv_o` |
| sd_dly1_o | output | 1 | `sd_o` delayed by one slot |
| sd_dly2_o | output | 1 | `sd_o` delayed by two slots |

## Verification
The assertions assume word select changes only at slot boundaries, so the stored position counter restarts at zero exactly when the sampled word select flips. They also assume the mode input is held steady while a comparison between the straight and inverted outputs is being made. The stimulus builds every run from whole 32-bit slots with strictly alternating word select, and changes the mode only under reset. It fills the bits outside the sample window with non-zero filler, so that any leakage into the outputs shows up. Sample values cycle through the two's-complement extremes (0, 1, -1, -32768, 32767, -32767) and arithmetic filler. Runs start with word select both low and high.

// File: rtl/aps_pkg.sv
package aps_pkg;

    typedef enum logic {
        MODE_FLIP   = 1'b0,
        MODE_NEGATE = 1'b1
    } inv_mode_e;

    typedef struct packed {
        logic norm;
        logic inv;
        logic ws;
        logic ws_inv;
        logic dly1;
        logic dly2;
    } out_bits_t;

endpackage

// File: rtl/aps_frame_tracker.sv
module aps_frame_tracker #(
    parameter int SLOT_BITS = 32,
    parameter int CW        = $clog2(SLOT_BITS) + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ws_i,
    output logic [CW-1:0] pos_o,
    output logic          en_o
);
    localparam logic [CW-1:0] POS_MAX = '1;

    typedef struct packed {
        logic          seen;
        logic          ws;
        logic [CW-1:0] pos;
        logic [1:0]    edges;
    } trk_t;

    trk_t s_q, s_d;
    logic mark;

    always_comb begin
        s_d     = s_q;
        // marker: sampled word select against its one-cycle delayed copy
        mark    = s_q.seen && (ws_i ^ s_q.ws);
        s_d.seen = 1'b1;
        s_d.ws   = ws_i;
        if (mark) begin
            s_d.pos = '0;
        end else if (s_q.pos != POS_MAX) begin
            s_d.pos = s_q.pos + 1'b1;
        end
        if (mark && (s_q.edges != 2'd2)) begin
            s_d.edges = s_q.edges + 2'd1;
        end
        pos_o = s_d.pos;
        en_o  = (s_d.edges == 2'd2);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{seen: 1'b0, ws: 1'b0, pos: POS_MAX, edges: 2'd0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/aps_negator.sv
module aps_negator #(
    parameter int SAMPLE_BITS = 16,
    parameter int CW          = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] pos_i,
    input  logic          sd_i,
    input  logic          en_i,
    output logic          ex_o
);
    localparam logic [CW-1:0]          LAST_POS = CW'(SAMPLE_BITS);
    localparam logic [SAMPLE_BITS-1:0] MOST_NEG = {1'b1, {(SAMPLE_BITS-1){1'b0}}};

    typedef struct packed {
        logic [SAMPLE_BITS-1:0] cap;
        logic [SAMPLE_BITS-1:0] shf;
        logic                   have;
    } neg_t;

    neg_t s_q, s_d;
    logic                   win;
    logic                   last;
    logic [SAMPLE_BITS-1:0] word;
    logic [SAMPLE_BITS-1:0] negated;

    always_comb begin
        s_d     = s_q;
        win     = (pos_i != '0) && (pos_i <= LAST_POS);
        last    = (pos_i == LAST_POS);
        word    = {s_q.cap[SAMPLE_BITS-2:0], sd_i};
        negated = (word == MOST_NEG) ? ~MOST_NEG : (~word + 1'b1);
        ex_o    = 1'b0;
        if (win) begin
            s_d.cap = word;
            ex_o    = s_q.have & s_q.shf[SAMPLE_BITS-1];
            s_d.shf = {s_q.shf[SAMPLE_BITS-2:0], 1'b0};
        end
        if (last) begin
            s_d.shf = negated;
            if (en_i) begin
                s_d.have = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/aps_delay_line.sv
module aps_delay_line #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] tap1_o,
    output logic [WIDTH-1:0] tap2_o
);
    localparam int LEN = 2 * DEPTH;

    logic [LEN-1:0][WIDTH-1:0] sr_q, sr_d;

    always_comb begin
        sr_d   = {sr_q[LEN-2:0], din_i};
        tap1_o = sr_q[DEPTH-1];
        tap2_o = sr_q[LEN-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

endmodule

// File: rtl/audio_polarity_split.sv
module audio_polarity_split
    import aps_pkg::*;
#(
    parameter int SLOT_BITS   = 32,
    parameter int SAMPLE_BITS = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ws_i,
    input  logic sd_i,
    input  logic exact_i,
    output logic sd_o,
    output logic sd_inv_o,
    output logic ws_o,
    output logic ws_inv_o,
    output logic sd_dly1_o,
    output logic sd_dly2_o
);
    localparam int              CW      = $clog2(SLOT_BITS) + 1;
    localparam logic [CW-1:0]   LSB_POS = CW'(SAMPLE_BITS);

    typedef struct packed {
        logic          sd;
        logic          ws;
        logic [CW-1:0] pos;
        logic          en;
        logic          ex;
        inv_mode_e     mode;
    } stage_t;

    logic [CW-1:0] trk_pos;
    logic          trk_en;
    logic          neg_ex;
    logic [1:0]    dl_in, dl_tap1, dl_tap2;

    stage_t    a_q, a_d;
    out_bits_t o_q, o_d;
    logic      win_b, norm_b, ws_b, flip_b, negb_b;

    aps_frame_tracker #(.SLOT_BITS(SLOT_BITS), .CW(CW)) u_trk (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ws_i  (ws_i),
        .pos_o (trk_pos),
        .en_o  (trk_en)
    );

    aps_negator #(.SAMPLE_BITS(SAMPLE_BITS), .CW(CW)) u_neg (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pos_i (trk_pos),
        .sd_i  (sd_i),
        .en_i  (trk_en),
        .ex_o  (neg_ex)
    );

    // lane 0: straight data, lane 1: gated word select
    aps_delay_line #(.WIDTH(2), .DEPTH(SLOT_BITS)) u_dly (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .din_i (dl_in),
        .tap1_o(dl_tap1),
        .tap2_o(dl_tap2)
    );

    // rising-edge capture stage
    always_comb begin
        a_d.sd   = sd_i;
        a_d.ws   = ws_i;
        a_d.pos  = trk_pos;
        a_d.en   = trk_en;
        a_d.ex   = neg_ex;
        a_d.mode = exact_i ? MODE_NEGATE : MODE_FLIP;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            a_q <= '{sd: 1'b0, ws: 1'b0, pos: '1, en: 1'b0, ex: 1'b0, mode: MODE_FLIP};
        end else begin
            a_q <= a_d;
        end
    end

    // output formation, registered on the falling edge
    always_comb begin
        win_b  = a_q.en && (a_q.pos != '0) && (a_q.pos <= LSB_POS);
        norm_b = win_b & a_q.sd;
        ws_b   = a_q.en & a_q.ws;
        flip_b = win_b & ((a_q.pos == LSB_POS) ? a_q.sd : ~a_q.sd);
        negb_b = win_b & a_q.ex;
        dl_in  = {ws_b, norm_b};

        o_d.norm   = norm_b;
        o_d.ws     = ws_b;
        o_d.dly1   = dl_tap1[0];
        o_d.dly2   = dl_tap2[0];
        if (a_q.mode == MODE_NEGATE) begin
            o_d.inv    = negb_b;
            o_d.ws_inv = dl_tap1[1];
        end else begin
            o_d.inv    = flip_b;
            o_d.ws_inv = ws_b;
        end
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign sd_o      = o_q.norm;
    assign sd_inv_o  = o_q.inv;
    assign ws_o      = o_q.ws;
    assign ws_inv_o  = o_q.ws_inv;
    assign sd_dly1_o = o_q.dly1;
    assign sd_dly2_o = o_q.dly2;

endmodule

// File: rtl/aps_checker.sv
module aps_checker
    import aps_pkg::*;
#(
    parameter int SAMPLE_BITS = 16,
    parameter int CW          = 6
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [CW-1:0] a_pos_i,
    input logic          a_en_i,
    input logic          a_ws_i,
    input inv_mode_e     a_mode_i,
    input logic          sd_o,
    input logic          sd_inv_o,
    input logic          ws_o,
    input logic          ws_inv_o,
    input logic          sd_dly1_o,
    input logic          sd_dly2_o
);
    localparam logic [CW-1:0] LSB_POS = CW'(SAMPLE_BITS);
    localparam logic [CW-1:0] POS_MAX = '1;

    AST_QUIET_BEFORE_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !a_en_i |-> !(sd_o | sd_inv_o | ws_o | ws_inv_o | sd_dly1_o | sd_dly2_o)); // R2

    AST_POS_ZERO_ON_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_en_i && $past(a_en_i) && (a_ws_i != $past(a_ws_i))) |-> (a_pos_i == '0)); // R1

    AST_POS_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_en_i && $past(a_en_i) && (a_ws_i == $past(a_ws_i)) && ($past(a_pos_i) != POS_MAX))
        |-> (a_pos_i == CW'($past(a_pos_i) + 1'b1))); // R1

    AST_OUTSIDE_WINDOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((a_pos_i == '0) || (a_pos_i > LSB_POS)) |-> (!sd_o && !sd_inv_o)); // R3

    AST_FLIP_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_en_i && (a_mode_i == MODE_FLIP) && (a_pos_i != '0) && (a_pos_i < LSB_POS))
        |-> (sd_inv_o != sd_o)); // R4

    AST_FLIP_LSB_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_en_i && (a_mode_i == MODE_FLIP) && (a_pos_i == LSB_POS)) |-> (sd_inv_o == sd_o)); // R4

    AST_FLIP_WS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_mode_i == MODE_FLIP) |-> (ws_inv_o == ws_o)); // R7

endmodule

bind audio_polarity_split aps_checker #(.SAMPLE_BITS(SAMPLE_BITS), .CW(CW)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_pos_i  (a_q.pos),
    .a_en_i   (a_q.en),
    .a_ws_i   (a_q.ws),
    .a_mode_i (a_q.mode),
    .sd_o     (sd_o),
    .sd_inv_o (sd_inv_o),
    .ws_o     (ws_o),
    .ws_inv_o (ws_inv_o),
    .sd_dly1_o(sd_dly1_o),
    .sd_dly2_o(sd_dly2_o)
);

// File: tb/audio_polarity_split_bench.sv
module audio_polarity_split_bench;
    localparam int SLOT  = 32;
    localparam int SB    = 16;
    localparam int NSLOT = 70;
    localparam int NB    = NSLOT * SLOT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ws = 1'b0;
    logic sd = 1'b0;
    logic exact = 1'b0;
    logic sd_o, sd_inv_o, ws_o, ws_inv_o, sd_dly1_o, sd_dly2_o;

    int checks = 0;
    int fails  = 0;
    int phase  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    audio_polarity_split u_audio_polarity_split (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .ws_i     (ws),
        .sd_i     (sd),
        .exact_i  (exact),
        .sd_o     (sd_o),
        .sd_inv_o (sd_inv_o),
        .ws_o     (ws_o),
        .ws_inv_o (ws_inv_o),
        .sd_dly1_o(sd_dly1_o),
        .sd_dly2_o(sd_dly2_o)
    );

    function automatic logic [15:0] smp(int s);
        case (s % 10)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'h8000;
            4: return 16'h7FFF;
            5: return 16'h8001;
            default: return 16'((s * 40503 + phase * 911) ^ (s << 9));
        endcase
    endfunction

    function automatic logic [15:0] negv(logic [15:0] x);
        if (x == 16'h8000) return 16'h7FFF;
        return 16'(~x + 16'd1);
    endfunction

    function automatic logic in_ws(int b);
        return logic'((b / SLOT) % 2) ^ logic'(phase % 2);
    endfunction

    function automatic logic in_win(int b);
        return ((b % SLOT) >= 1) && ((b % SLOT) <= SB);
    endfunction

    function automatic logic in_sd(int b);
        logic [15:0] v;
        if (in_win(b)) begin
            v = smp(b / SLOT);
            return v[SB - (b % SLOT)];
        end
        return ((b * 13) % 5) < 3;
    endfunction

    function automatic logic e_en(int b);
        return (b >= 0) && ((b / SLOT) >= 2);
    endfunction

    function automatic logic e_norm(int b);
        if (!e_en(b) || !in_win(b)) return 1'b0;
        return in_sd(b);
    endfunction

    function automatic logic e_ws(int b);
        if (!e_en(b)) return 1'b0;
        return in_ws(b);
    endfunction

    function automatic logic e_inv(int b, bit md);
        logic [15:0] n;
        if (!e_en(b) || !in_win(b)) return 1'b0;
        if (md) begin
            if ((b / SLOT) < 3) return 1'b0;
            n = negv(smp(b / SLOT - 1));
            return n[SB - (b % SLOT)];
        end
        if ((b % SLOT) == SB) return in_sd(b);
        return ~in_sd(b);
    endfunction

    task automatic chk(string tag, logic act, logic exp, int b);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s bit %0d actual=%0b expected=%0b", tag, b, act, exp);
        end
    endtask

    task automatic check_bit(int b, bit md);
        string t_norm, t_inv;
        if (!e_en(b)) begin
            t_norm = "R2";
            t_inv  = "R2";
        end else begin
            t_norm = (((b % SLOT) == 1) || ((b % SLOT) == SB)) ? "R1" : "R3";
            if (md) t_inv = (smp(b / SLOT - 1) == 16'h8000) ? "R6" : "R5";
            else    t_inv = "R4";
        end
        chk(t_norm, sd_o, e_norm(b), b);
        chk(t_inv, sd_inv_o, e_inv(b, md), b);
        chk("R7", ws_o, e_ws(b), b);
        chk("R7", ws_inv_o, md ? e_ws(b - SLOT) : e_ws(b), b);
        chk("R8", sd_dly1_o, e_norm(b - SLOT), b);
        chk("R8", sd_dly2_o, e_norm(b - 2 * SLOT), b);
    endtask

    task automatic run(int ph, bit md);
        phase = ph;
        exact = md;
        rst_n = 1'b0;
        ws    = logic'(ph % 2);
        sd    = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        // R2: reset state of every output
        chk("R2", sd_o | sd_inv_o | ws_o | ws_inv_o | sd_dly1_o | sd_dly2_o, 1'b0, -1);
        rst_n = 1'b1;
        for (int b = 0; b <= NB; b++) begin
            @(negedge clk);
            #1;
            if (b > 0) check_bit(b - 1, md);
            if (b < NB) begin
                ws = in_ws(b);
                sd = in_sd(b);
                @(posedge clk);
                #1;
                // R9: rising edge has sampled bit b but outputs still show b-1
                if (b > 0) chk("R9", sd_o, e_norm(b - 1), b - 1);
            end
        end
    endtask

    initial begin
        run(0, 1'b0);
        run(0, 1'b1);
        run(1, 1'b1);
        run(1, 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule